// File: doc/BRIEF.md
# Signed-Digit Plus Binary Adder/Subtractor

This block adds an unsigned binary word to, or subtracts it from, a radix-2 signed-digit operand, with no carry chain across positions. Every signed digit travels on two wires, a plus rail and a minus rail. Each position looks only at its own operand digit, its own binary bit and the carry of the position just below. The delay is therefore the same for any word length. The result is an (N+1)-digit signed-digit number in the same two-rail form, so it can feed the next stage of an accumulate or multiply pipeline without being converted first.

Each position splits the sum of its digit and its bit into two parts: an interim value that is always 0 or -1, and a carry that is always 0 or +1. When a carry arrives from below, it meets an interim value of the opposite sign or a zero, so no second carry can arise. Subtraction reuses the same adder. The operand rails are exchanged, the binary word is added, and the result rails are exchanged again. A gate input forces the binary word to zero, which a multiplier needs for a zero multiplier bit. Any operand digit with both rails set raises an error flag.

The result can be taken straight from the logic or through one register stage, chosen by a parameter. The default is registered.

Top module: `sd_bin_adder`

## Requirements
- R1: Digits use two rails (plus, minus). Plus=0/minus=0 is 0, plus=1/minus=0 is +1, plus=0/minus=1 is -1, and both set is illegal. No result digit ever has both rails set.
- R2: With sub_sel=0 and bin_en=1, the value of the result is the value of the signed-digit operand plus bin_val as an unsigned number. Digit k carries weight 2^k.
- R3: With sub_sel=1 and bin_en=1, the value of the result is the operand value minus bin_val. For N=4, operand digits 0,-1,0,+1 (MSB first) minus 1001 gives digits -1,0,+1,0,0 (value -12).
- R4: With bin_en=0, bin_val has no effect. The result value equals the operand value in both add and subtract mode.
- R5: The top result digit (index N) is never -1 when adding and never +1 when subtracting.
- R6: bad_digit is 1 exactly when at least one operand digit has both rails set, and 0 otherwise.
- R7: With OUT_REG=1, the result and the flag appear on the clock edge after the inputs are applied. While rst_n is low, all result rails and bad_digit are 0.
- R8: For N=4, adding operand digits 0,-1,0,+1 (MSB first, value -3) and bin_val 1001 gives result digits +1,-1,-1,+1,0 (value 6). The same pattern appears in the low five digits for wider N when the upper inputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| sd_pos | input | N_DIGITS | Plus rail of the signed-digit operand, bit k is digit k |
| sd_neg | input | N_DIGITS | Minus rail of the signed-digit operand |
| bin_val | input | N_DIGITS | Unsigned binary operand |
| sub_sel | input | 1 | 0 adds the binary operand, 1 subtracts it |
| bin_en | input | 1 | 1 passes bin_val, 0 forces it to zero |
| res_pos | output | N_DIGITS+1 | Plus rail of the result |
| res_neg | output | N_DIGITS+1 | Minus rail of the result |
| bad_digit | output | 1 | An operand digit used the illegal code |

## Verification
Two fixed operand pairs, one added and one subtracted, have exact digit patterns. These show whether the carry is routed to the right neighbour and whether both rail swaps happen, since the value alone would hide a misplaced but equal-weight digit. Extreme operands stress the top digit's sign under both modes: all +1 plus all-ones binary, and all -1 minus all-ones binary. A gated vector with bin_val all ones shows whether the gate acts before the cell logic. Random mixes of digits, modes and gate settings, with an occasional illegal code, are compared by value against an integer model. This separates the add path from the subtract path and shows that a bad digit sets the flag without disturbing the flag on the vectors around it.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

    // Two-rail digit code: {plus, minus}
    typedef enum logic [1:0] {
        DIG_ZERO = 2'b00,
        DIG_NEG  = 2'b01,
        DIG_POS  = 2'b10,
        DIG_BAD  = 2'b11
    } sd_code_e;

    function automatic logic code_is_bad(input logic plus_b, input logic minus_b);
        sd_code_e code;
        code = sd_code_e'({plus_b, minus_b});
        return (code == DIG_BAD);
    endfunction

endpackage

// File: rtl/sdb_front.sv
module sdb_front #(
    parameter int N_DIGITS = 8
) (
    input  logic [N_DIGITS-1:0] sd_pos,
    input  logic [N_DIGITS-1:0] sd_neg,
    input  logic [N_DIGITS-1:0] bin_val,
    input  logic                sub_sel,
    input  logic                bin_en,
    output logic [N_DIGITS-1:0] op_pos,
    output logic [N_DIGITS-1:0] op_neg,
    output logic [N_DIGITS-1:0] op_bin,
    output logic                any_bad
);
    import sdb_pkg::*;

    logic [N_DIGITS-1:0] bad_vec;

    // Negation of the SD operand is an exchange of rails.
    always_comb begin
        if (sub_sel) begin
            op_pos = sd_neg;
            op_neg = sd_pos;
        end else begin
            op_pos = sd_pos;
            op_neg = sd_neg;
        end
    end

    // Gate for the binary word.
    always_comb begin
        op_bin = bin_en ? bin_val : '0;
    end

    for (genvar g = 0; g < N_DIGITS; g++) begin : g_chk
        always_comb begin
            bad_vec[g] = code_is_bad(sd_pos[g], sd_neg[g]);
        end
    end

    always_comb begin
        any_bad = |bad_vec;
    end

endmodule

// File: rtl/sdb_cell.sv
module sdb_cell (
    input  logic d_pos,
    input  logic d_neg,
    input  logic b_bit,
    output logic carry_up,
    output logic z_neg
);
    // digit + bit = 2*carry_up - z_neg, carry in {0,+1}, interim in {0,-1}
    always_comb begin
        carry_up = d_pos | (b_bit & ~d_neg);
        z_neg    = (d_pos | d_neg) ^ b_bit;
    end
endmodule

// File: rtl/sdb_recombine.sv
module sdb_recombine #(
    parameter int N_DIGITS = 8
) (
    input  logic [N_DIGITS-1:0] carry_vec,
    input  logic [N_DIGITS-1:0] zneg_vec,
    input  logic                sub_sel,
    output logic [N_DIGITS:0]   sum_pos,
    output logic [N_DIGITS:0]   sum_neg
);
    logic [N_DIGITS:0] raw_pos;
    logic [N_DIGITS:0] raw_neg;
    logic [N_DIGITS:0] cin_vec;

    always_comb begin
        cin_vec = {carry_vec, 1'b0};
    end

    for (genvar g = 0; g < N_DIGITS; g++) begin : g_pos
        always_comb begin
            raw_pos[g] = ~zneg_vec[g] & cin_vec[g];
            raw_neg[g] =  zneg_vec[g] & ~cin_vec[g];
        end
    end

    always_comb begin
        raw_pos[N_DIGITS] = cin_vec[N_DIGITS];
        raw_neg[N_DIGITS] = 1'b0;
    end

    // Undo the operand negation for subtraction.
    always_comb begin
        if (sub_sel) begin
            sum_pos = raw_neg;
            sum_neg = raw_pos;
        end else begin
            sum_pos = raw_pos;
            sum_neg = raw_neg;
        end
    end

endmodule

// File: rtl/sdb_out_stage.sv
module sdb_out_stage #(
    parameter int WIDTH   = 19,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d_out <= '0;
            end else begin
                d_out <= d_in;
            end
        end
    end else begin : g_wire
        always_comb begin
            d_out = d_in;
        end
    end
endmodule

// File: rtl/sd_bin_adder.sv
module sd_bin_adder #(
    parameter int N_DIGITS = 8,
    parameter bit OUT_REG  = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_DIGITS-1:0] sd_pos,
    input  logic [N_DIGITS-1:0] sd_neg,
    input  logic [N_DIGITS-1:0] bin_val,
    input  logic                sub_sel,
    input  logic                bin_en,
    output logic [N_DIGITS:0]   res_pos,
    output logic [N_DIGITS:0]   res_neg,
    output logic                bad_digit
);
    localparam int RES_W = N_DIGITS + 1;
    localparam int PACK_W = 2 * RES_W + 1;

    logic [N_DIGITS-1:0] op_pos;
    logic [N_DIGITS-1:0] op_neg;
    logic [N_DIGITS-1:0] op_bin;
    logic                any_bad;
    logic [N_DIGITS-1:0] carry_vec;
    logic [N_DIGITS-1:0] zneg_vec;
    logic [RES_W-1:0]    sum_pos;
    logic [RES_W-1:0]    sum_neg;
    logic [PACK_W-1:0]   pack_d;
    logic [PACK_W-1:0]   pack_q;

    sdb_front #(.N_DIGITS(N_DIGITS)) u_front (
        .sd_pos  (sd_pos),
        .sd_neg  (sd_neg),
        .bin_val (bin_val),
        .sub_sel (sub_sel),
        .bin_en  (bin_en),
        .op_pos  (op_pos),
        .op_neg  (op_neg),
        .op_bin  (op_bin),
        .any_bad (any_bad)
    );

    for (genvar g = 0; g < N_DIGITS; g++) begin : g_cell
        sdb_cell u_cell (
            .d_pos    (op_pos[g]),
            .d_neg    (op_neg[g]),
            .b_bit    (op_bin[g]),
            .carry_up (carry_vec[g]),
            .z_neg    (zneg_vec[g])
        );
    end

    sdb_recombine #(.N_DIGITS(N_DIGITS)) u_recomb (
        .carry_vec (carry_vec),
        .zneg_vec  (zneg_vec),
        .sub_sel   (sub_sel),
        .sum_pos   (sum_pos),
        .sum_neg   (sum_neg)
    );

    always_comb begin
        pack_d = {any_bad, sum_pos, sum_neg};
    end

    sdb_out_stage #(.WIDTH(PACK_W), .OUT_REG(OUT_REG)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pack_d),
        .d_out (pack_q)
    );

    always_comb begin
        bad_digit = pack_q[PACK_W-1];
        res_pos   = pack_q[2*RES_W-1:RES_W];
        res_neg   = pack_q[RES_W-1:0];
    end

endmodule

// File: rtl/sd_bin_adder_chk.sv
module sd_bin_adder_chk #(
    parameter int N_DIGITS = 8,
    parameter bit OUT_REG  = 1'b1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_DIGITS-1:0] sd_pos,
    input logic [N_DIGITS-1:0] sd_neg,
    input logic [N_DIGITS-1:0] bin_val,
    input logic                sub_sel,
    input logic                bin_en,
    input logic [N_DIGITS:0]   res_pos,
    input logic [N_DIGITS:0]   res_neg,
    input logic                bad_digit
);
    function automatic int dig_sum(input logic [N_DIGITS:0] p, input logic [N_DIGITS:0] n);
        int acc;
        acc = 0;
        for (int k = 0; k <= N_DIGITS; k++) begin
            acc = acc + ((p[k] ? 1 : 0) - (n[k] ? 1 : 0)) * (1 << k);
        end
        return acc;
    endfunction

    int   in_val;
    int   out_val;
    int   add_val;
    int   sub_val;
    logic in_bad;
    logic live_q;

    always_comb begin
        in_val  = dig_sum({1'b0, sd_pos}, {1'b0, sd_neg});
        out_val = dig_sum(res_pos, res_neg);
        add_val = in_val + (bin_en ? int'(bin_val) : 0);
        sub_val = in_val - (bin_en ? int'(bin_val) : 0);
        in_bad  = |(sd_pos & sd_neg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R1: result rails never both set
    p_rails_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_pos & res_neg) == '0);

    if (OUT_REG) begin : g_seq
        p_sum_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
            live_q && !$past(in_bad) && !$past(sub_sel) |-> out_val == $past(add_val));
        p_sum_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
            live_q && !$past(in_bad) && $past(sub_sel) |-> out_val == $past(sub_val));
        p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
            live_q && !$past(in_bad) && !$past(bin_en) |-> out_val == $past(in_val));
        p_top_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
            live_q |-> ($past(sub_sel) ? !res_pos[N_DIGITS] : !res_neg[N_DIGITS]));
        p_bad_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
            live_q |-> bad_digit == $past(in_bad));
    end else begin : g_comb
        p_sum_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !in_bad && !sub_sel |-> out_val == add_val);
        p_sum_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !in_bad && sub_sel |-> out_val == sub_val);
        p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !in_bad && !bin_en |-> out_val == in_val);
        p_top_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
            sub_sel ? !res_pos[N_DIGITS] : !res_neg[N_DIGITS]);
        p_bad_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
            bad_digit == in_bad);
    end

endmodule

bind sd_bin_adder sd_bin_adder_chk #(.N_DIGITS(N_DIGITS), .OUT_REG(OUT_REG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sd_pos    (sd_pos),
    .sd_neg    (sd_neg),
    .bin_val   (bin_val),
    .sub_sel   (sub_sel),
    .bin_en    (bin_en),
    .res_pos   (res_pos),
    .res_neg   (res_neg),
    .bad_digit (bad_digit)
);

// File: tb/sd_bin_adder_bench.sv
module sd_bin_adder_bench;
    localparam int N = 8;

    typedef struct {
        int              val;
        bit              bad;
        bit              sub;
        bit              has_pat;
        logic [N:0]      pat_pos;
        logic [N:0]      pat_neg;
        string           tag;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   sd_pos = '0;
    logic [N-1:0]   sd_neg = '0;
    logic [N-1:0]   bin_val = '0;
    logic           sub_sel = 1'b0;
    logic           bin_en = 1'b0;
    logic [N:0]     res_pos;
    logic [N:0]     res_neg;
    logic           bad_digit;

    int   n_checks = 0;
    int   n_fail = 0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    sd_bin_adder #(.N_DIGITS(N), .OUT_REG(1'b1)) u_sd_bin_adder (
        .clk(clk), .rst_n(rst_n), .sd_pos(sd_pos), .sd_neg(sd_neg),
        .bin_val(bin_val), .sub_sel(sub_sel), .bin_en(bin_en),
        .res_pos(res_pos), .res_neg(res_neg), .bad_digit(bad_digit)
    );

    function automatic int val_of(input logic [N:0] p, input logic [N:0] n);
        int acc = 0;
        for (int k = 0; k <= N; k++) begin
            if (p[k]) acc += (1 << k);
            if (n[k]) acc -= (1 << k);
        end
        return acc;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic compare_front();
        exp_t e;
        int   got;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        got = val_of(res_pos, res_neg);
        check(bad_digit == e.bad, "R6 bad flag", int'(bad_digit), int'(e.bad));
        check((res_pos & res_neg) == '0, "R1 rails exclusive", int'(res_pos & res_neg), 0);
        if (e.sub) check(!res_pos[N], "R5 top digit sub", int'(res_pos[N]), 0);
        else       check(!res_neg[N], "R5 top digit add", int'(res_neg[N]), 0);
        if (!e.bad) check(got == e.val, e.tag, got, e.val);
        if (e.has_pat) begin
            check(res_pos == e.pat_pos, {e.tag, " plus rail"}, int'(res_pos), int'(e.pat_pos));
            check(res_neg == e.pat_neg, {e.tag, " minus rail"}, int'(res_neg), int'(e.pat_neg));
        end
    endtask

    task automatic step(input logic [N-1:0] p, input logic [N-1:0] n, input logic [N-1:0] b,
                        input bit sub, input bit en, input bit has_pat,
                        input logic [N:0] pp, input logic [N:0] pn, input string tag);
        exp_t e;
        int   opv = 0;
        @(negedge clk);
        compare_front();
        sd_pos = p; sd_neg = n; bin_val = b; sub_sel = sub; bin_en = en;
        for (int k = 0; k < N; k++) begin
            if (p[k]) opv += (1 << k);
            if (n[k]) opv -= (1 << k);
        end
        e.bad = |(p & n);
        e.sub = sub;
        e.val = en ? (sub ? opv - int'(b) : opv + int'(b)) : opv;
        e.has_pat = has_pat;
        e.pat_pos = pp;
        e.pat_neg = pn;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        // R7: outputs cleared while reset held, even with active inputs
        sd_pos = 8'h0F; bin_val = 8'hFF; bin_en = 1'b1;
        repeat (3) @(negedge clk);
        check(res_pos == '0 && res_neg == '0, "R7 reset result", int'(res_pos | res_neg), 0);
        check(bad_digit == 1'b0, "R7 reset flag", int'(bad_digit), 0);
        rst_n = 1'b1;
        sd_pos = '0; bin_val = '0;

        // R8: digits 0,-1,0,+1 (=-3) + 1001 -> +1,-1,-1,+1,0 (=6)
        step(8'b0000_0001, 8'b0000_0100, 8'b0000_1001, 1'b0, 1'b1, 1'b1,
             9'b0_0001_0010, 9'b0_0000_1100, "R8 worked add");
        // R3: same operands subtracted -> -1,0,+1,0,0 (=-12)
        step(8'b0000_0001, 8'b0000_0100, 8'b0000_1001, 1'b1, 1'b1, 1'b1,
             9'b0_0000_0100, 9'b0_0001_0000, "R3 worked sub");
        // R7: latency, after one zero vector result follows
        step('0, '0, '0, 1'b0, 1'b1, 1'b1, '0, '0, "R7 zero vector");
        // R4: gate off, bin all ones
        step(8'b0101_0000, 8'b0000_0011, 8'hFF, 1'b0, 1'b0, 1'b0, '0, '0, "R4 gated add");
        step(8'b0101_0000, 8'b0000_0011, 8'hFF, 1'b1, 1'b0, 1'b0, '0, '0, "R4 gated sub");
        // R2/R5 extremes
        step(8'hFF, 8'h00, 8'hFF, 1'b0, 1'b1, 1'b0, '0, '0, "R2 max add");
        step(8'h00, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0, '0, '0, "R3 min sub");
        step(8'h00, 8'hFF, 8'hFF, 1'b0, 1'b1, 1'b0, '0, '0, "R2 min add");
        step(8'hFF, 8'h00, 8'hFF, 1'b1, 1'b1, 1'b0, '0, '0, "R3 max sub");
        // R6: one illegal digit, then clean vector
        step(8'b0010_0000, 8'b0010_0000, 8'h05, 1'b0, 1'b1, 1'b0, '0, '0, "R6 bad digit");
        step(8'b0000_0010, 8'b0000_0000, 8'h05, 1'b0, 1'b1, 1'b0, '0, '0, "R6 clean after bad");

        for (int v = 0; v < 3000; v++) begin
            logic [N-1:0] rp, rn;
            bit           sub, en;
            rp = '0; rn = '0;
            for (int k = 0; k < N; k++) begin
                int r = int'($urandom % 3);
                if (r == 1) rp[k] = 1'b1;
                if (r == 2) rn[k] = 1'b1;
            end
            if (($urandom % 16) == 0) begin
                int bk = int'($urandom % N);
                rp[bk] = 1'b1; rn[bk] = 1'b1;
            end
            sub = bit'($urandom % 2);
            en  = (($urandom % 4) != 0);
            step(rp, rn, N'($urandom), sub, en, 1'b0, '0, '0,
                 sub ? (en ? "R3 random sub" : "R4 random gated") :
                       (en ? "R2 random add" : "R4 random gated"));
        end
        step('0, '0, '0, 1'b0, 1'b0, 1'b0, '0, '0, "R2 flush");
        @(negedge clk);
        compare_front();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule